// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

The block turns one parallel character per request into an asynchronous serial frame on a single output line. A frame is a low start bit, 5 to 9 data bits sent least significant bit first, an optional parity bit and a high stop period. Bit timing comes from an external enable `tick_i` that pulses at sixteen times the bit rate. Every bit lasts a fixed number of those pulses.

Format inputs set the frame shape. They select the character length, whether parity is added and how it is formed, and the stop length. The block samples them when it accepts a request, so a frame keeps one shape from start to end. A separate break input pulls the line low for as long as it is set. It overrides whatever the frame would drive, but the frame's timing keeps running underneath. `busy_o` covers the whole frame. `done_o` marks the cycle in which the line returns to idle.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset `txd_o` is 1 and `busy_o` and `done_o` are 0. The line stays at 1 whenever no frame is active and break is clear.
- R2: A request (`start_i`=1) made while `busy_o`=0 is accepted at that clock edge. From the next cycle `busy_o`=1 and the line carries a 0 start bit for 16 ticks. A request made while `busy_o`=1 is ignored.
- R3: Data bits follow the start bit LSB first, each lasting 16 ticks. The length field `lc_len_i` selects the data bit count: 00 = 5, 01 = 6, 10 = 7, 11 = 8.
- R4: With `lc_nine_i`=1 and `lc_len_i`=00 the character has 9 data bits. With `lc_nine_i`=1 and any other length code, the length field alone decides the count.
- R5: A parity bit of 16 ticks follows the data only when `lc_par_en_i`=1. Otherwise the stop period follows the last data bit directly.
- R6: With parity on and `lc_stick_i`=0, `lc_even_i`=1 makes the number of ones across the sent data bits and the parity bit even. `lc_even_i`=0 makes that number odd.
- R7: With parity on and `lc_stick_i`=1, the parity bit is 1 when `lc_even_i`=0 and 0 when `lc_even_i`=1, whatever the data.
- R8: The stop period is high. With `lc_stop_i`=0 it lasts 16 ticks. With `lc_stop_i`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for all other lengths.
- R9: While `lc_brk_i`=1 the line is 0 in the same cycle, whether a frame is active or not. Frame timing, `busy_o` and `done_o` are unaffected by break.
- R10: Data and format inputs are captured at acceptance. Changing them during a frame has no effect on that frame.
- R11: The edge that consumes the last stop tick clears `busy_o` and raises `done_o` for exactly one cycle. A request present in that cycle is accepted, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 per bit |
| start_i | input | 1 | Request to send `data_i` |
| data_i | input | 9 | Character, LSB sent first |
| lc_len_i | input | 2 | Length code, 5 to 8 bits |
| lc_nine_i | input | 1 | 9-bit mode, used with length code 00 |
| lc_par_en_i | input | 1 | Add a parity bit |
| lc_even_i | input | 1 | Even parity select, also the stick value selector |
| lc_stick_i | input | 1 | Fixed parity value |
| lc_stop_i | input | 1 | Long stop period |
| lc_brk_i | input | 1 | Hold the line low |
| txd_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
The assertions take `tick_i` to be a single-cycle enable that recurs. Without it a frame never ends and the properties tying `done_o` to the fall of `busy_o` are never exercised.

They also treat break as a live override. Requests, format changes and break may all arrive at any cycle, including mid-frame and in the cycle `done_o` is high.

The stimulus drives every input between clock edges. It runs the tick at both one-per-cycle and slower rates. It raises break and changes the format fields while frames are in flight, so the reference model sees those inputs in exactly the state the design does.

// File: rtl/uart_frame_tx_pkg.sv
package uart_frame_tx_pkg;
  localparam int DATA_W = 9;
  localparam int NBW    = 4;

  typedef struct packed {
    logic [1:0] len;
    logic       nine;
    logic       par_en;
    logic       even;
    logic       stick;
    logic       stop;
  } lc_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} st_e;

  function automatic logic [NBW-1:0] char_bits(lc_t c);
    if (c.nine && c.len == 2'b00) return NBW'(9);
    return NBW'(5) + NBW'(c.len);
  endfunction
endpackage

// File: rtl/uart_tx_bit_timer.sv
module uart_tx_bit_timer #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (clear_i)      cnt_q <= '0;
    else if (tick_i)       cnt_q <= (cnt_q == limit_i) ? '0 : cnt_q + 1'b1;
  end

  assign last_o = tick_i && !clear_i && (cnt_q == limit_i);
endmodule

// File: rtl/uart_tx_parity.sv
module uart_tx_parity
  import uart_frame_tx_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [NBW-1:0]    nbits_i,
  input  logic              even_i,
  input  logic              stick_i,
  output logic              par_o
);
  logic [DATA_W-1:0] mask;
  logic              ones_odd;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign mask[i] = (NBW'(i) < nbits_i);
  end

  assign ones_odd = ^(data_i & mask);
  // stick: fixed value selected by even_i; else complete even/odd count
  assign par_o = stick_i ? ~even_i : (even_i ? ones_odd : ~ones_odd);
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uart_frame_tx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        lc_len_i,
  input  logic              lc_nine_i,
  input  logic              lc_par_en_i,
  input  logic              lc_even_i,
  input  logic              lc_stick_i,
  input  logic              lc_stop_i,
  input  logic              lc_brk_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int CW = $clog2(2 * OSR);
  localparam logic [CW-1:0] BIT_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] STOP_1   = CW'(OSR - 1);
  localparam logic [CW-1:0] STOP_15  = CW'(OSR + OSR / 2 - 1);
  localparam logic [CW-1:0] STOP_2   = CW'(2 * OSR - 1);

  st_e               st_q;
  logic [DATA_W-1:0] shreg_q;
  logic [NBW-1:0]    nbits_q, idx_q;
  logic              par_en_q, par_q, done_q;
  logic [CW-1:0]     stop_last_q, limit;
  logic              accept, last, par_in, frame_bit;
  lc_t               lc_in;
  logic [NBW-1:0]    nbits_in;

  assign lc_in    = '{len: lc_len_i, nine: lc_nine_i, par_en: lc_par_en_i,
                      even: lc_even_i, stick: lc_stick_i, stop: lc_stop_i};
  assign nbits_in = char_bits(lc_in);
  assign accept   = (st_q == ST_IDLE) && start_i;
  assign limit    = (st_q == ST_STOP) ? stop_last_q : BIT_LAST;

  uart_tx_parity u_par (
    .data_i  (data_i),
    .nbits_i (nbits_in),
    .even_i  (lc_in.even),
    .stick_i (lc_in.stick),
    .par_o   (par_in)
  );

  uart_tx_bit_timer #(.CW(CW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .tick_i  (tick_i),
    .limit_i (limit),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      shreg_q     <= '0;
      nbits_q     <= '0;
      idx_q       <= '0;
      par_en_q    <= 1'b0;
      par_q       <= 1'b0;
      stop_last_q <= STOP_1;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q        <= ST_START;
        shreg_q     <= data_i;
        nbits_q     <= nbits_in;
        par_en_q    <= lc_in.par_en;
        par_q       <= par_in;
        stop_last_q <= !lc_in.stop ? STOP_1 :
                       (nbits_in == NBW'(5)) ? STOP_15 : STOP_2;
      end else if (last) begin
        unique case (st_q)
          ST_START: begin
            st_q  <= ST_DATA;
            idx_q <= '0;
          end
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            if (idx_q == nbits_q - NBW'(1)) st_q <= par_en_q ? ST_PAR : ST_STOP;
            else                            idx_q <= idx_q + NBW'(1);
          end
          ST_PAR: st_q <= ST_STOP;
          ST_STOP: begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_START: frame_bit = 1'b0;
      ST_DATA:  frame_bit = shreg_q[0];
      ST_PAR:   frame_bit = par_q;
      default:  frame_bit = 1'b1;
    endcase
  end

  assign txd_o  = lc_brk_i ? 1'b0 : frame_bit;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/uart_frame_tx_chk.sv
module uart_frame_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic start_i,
  input logic lc_brk_i,
  input logic txd_o,
  input logic busy_o,
  input logic done_o
);
  AST_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !lc_brk_i) |-> txd_o); // R1
  AST_START_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o); // R2
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lc_brk_i |-> !txd_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && $past(tick_i))); // R11
  AST_FALL_HAS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o); // R11
endmodule

bind uart_frame_tx uart_frame_tx_chk chk_i (.*);

// File: tb/uart_frame_tx_tb_top.sv
module uart_frame_tx_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] data_i = '0;
  logic [1:0] lc_len_i = '0;
  logic       lc_nine_i = 1'b0, lc_par_en_i = 1'b0, lc_even_i = 1'b0;
  logic       lc_stick_i = 1'b0, lc_stop_i = 1'b0, lc_brk_i = 1'b0;
  logic       txd_o, busy_o, done_o;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  int    tick_per = 1, tick_ph = 0;
  string cur_req = "R1";

  always #10 clk_i = ~clk_i;

  uart_frame_tx dut_i (.*);

  // tick pattern
  always @(posedge clk_i) begin
    #1;
    if (tick_ph >= tick_per - 1) begin tick_ph = 0; tick_i = 1'b1; end
    else begin tick_ph++; tick_i = 1'b0; end
  end

  // reference model: queue of line levels, one entry per tick
  bit q[$];
  bit done_exp = 1'b0;

  task automatic build_frame();
    int n, ones, stop_t;
    bit par;
    n = (lc_nine_i && lc_len_i == 2'b00) ? 9 : 5 + int'(lc_len_i);
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(data_i[i]);
    if (lc_stick_i) par = !lc_even_i;
    else            par = lc_even_i ? (ones % 2 == 1) : (ones % 2 == 0);
    stop_t = !lc_stop_i ? 16 : (n == 5 ? 24 : 32);
    repeat (16) q.push_back(1'b0);
    for (int i = 0; i < n; i++) repeat (16) q.push_back(data_i[i]);
    if (lc_par_en_i) repeat (16) q.push_back(par);
    repeat (stop_t) q.push_back(1'b1);
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    bit was_busy;
    if (!rst_ni) begin
      q.delete();
      done_exp = 1'b0;
    end else begin
      was_busy = (q.size() != 0);
      done_exp = 1'b0;
      if (was_busy && tick_i) begin
        void'(q.pop_front());
        if (q.size() == 0) done_exp = 1'b1;
      end
      if (!was_busy && start_i) build_frame();
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    logic exp_txd;
    exp_txd = lc_brk_i ? 1'b0 : ((q.size() != 0) ? q[0] : 1'b1);
    chk(cur_req, "txd", txd_o, exp_txd);
    chk(cur_req, "busy", busy_o, logic'(q.size() != 0));
    chk(cur_req, "done", done_o, done_exp);
  end

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic set_lc(logic [1:0] len, logic nine, logic pen, logic even,
                        logic stick, logic stop);
    lc_len_i = len; lc_nine_i = nine; lc_par_en_i = pen;
    lc_even_i = even; lc_stick_i = stick; lc_stop_i = stop;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk_i);
  endtask

  task automatic wait_done();
    @(negedge clk_i);
    while (!done_o) @(negedge clk_i);
  endtask

  task automatic send(string req, logic [8:0] d, logic [1:0] len, logic nine,
                      logic pen, logic even, logic stick, logic stop);
    wait_idle();
    cur_req = req;
    data_i = d;
    set_lc(len, nine, pen, even, stick, stop);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state checked by the per-cycle compare
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);

    tick_per = 1;
    for (int l = 0; l < 4; l++) send("R3", 9'h0B5 ^ 9'(l * 37), 2'(l), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R4", 9'h1A5, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    send("R4", 9'h1FF, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

    tick_per = 3;
    send("R5", 9'h055, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R6", 9'h0C3, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R6", 9'h0C7, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R6", 9'h0C3, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R6", 9'h113, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    send("R6", 9'h01D, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    send("R7", 9'h0F0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    send("R7", 9'h0F1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);

    tick_per = 2;
    send("R8", 9'h015, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R8", 9'h03A, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    send("R8", 9'h0A5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    send("R8", 9'h15A, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

    // R9 break while idle, then across a frame
    wait_idle();
    cur_req = "R9";
    lc_brk_i = 1'b1;
    repeat (10) @(negedge clk_i);
    data_i = 9'h0FF;
    set_lc(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (60) @(negedge clk_i);
    lc_brk_i = 1'b0;
    repeat (50) @(negedge clk_i);
    lc_brk_i = 1'b1;
    repeat (40) @(negedge clk_i);
    lc_brk_i = 1'b0;
    wait_done();

    // R10 format and data change mid-frame
    wait_idle();
    cur_req = "R10";
    data_i = 9'h0A6;
    set_lc(2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (45) @(negedge clk_i);
    data_i = 9'h159;
    set_lc(2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    wait_done();

    // R2 request held through a busy frame, R11 back-to-back
    tick_per = 1;
    wait_idle();
    cur_req = "R2";
    data_i = 9'h033;
    set_lc(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    start_i = 1'b1;
    repeat (3) @(negedge clk_i);
    data_i = 9'h00C;
    wait_done();
    cur_req = "R11";
    data_i = 9'h0E1;
    set_lc(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    wait_done();
    start_i = 1'b0;
    repeat (20) @(negedge clk_i);

    report();
  end
endmodule